// File: doc/BRIEF.md
# Corrected Error Count Accumulator

This block keeps wide running totals of corrected memory errors for one channel with up to three DIMMs. The memory controller has a narrow 15-bit counter per DIMM that runs freely and wraps around. These counters arrive packed into 32-bit raw status words. Each time a poll strobe is seen, the block samples the raw words and works out how far each counter has moved since the last sample, allowing for a wrap. It adds that change to a 32-bit total for the matching DIMM, and a total stops at all ones instead of wrapping.

The first poll after reset or after a clear does not add anything. It only stores the raw values as a baseline. An availability flag stays low until that first poll has been taken. While the flag is low, every total reads zero, which a consumer must treat as "unavailable". A synchronous clear returns the totals, the baselines and the flag to their reset state.

Top module: `ce_tally`

## Requirements
- R1: While reset is asserted and directly after it is released, every total is 0 and the availability flag `avail_o` is 0.
- R2: Field positions. The DIMM0 count is bits 14:0 of raw word 0 (`raw_i[14:0]`). The DIMM1 count is bits 30:16 of word 0 (`raw_i[30:16]`). The DIMM2 count is bits 14:0 of word 1 (`raw_i[46:32]`). All other raw bits have no effect on any output.
- R3: The first poll after reset or clear stores the baseline only. The totals stay 0 and `avail_o` reads 1 from the next cycle on.
- R4: On a later poll where a field is greater than or equal to its stored baseline, the total for that DIMM grows by current minus baseline. The baseline is then replaced by the current value.
- R5: On a later poll where a field is below its baseline (the counter has wrapped), the total grows by current + 32768 − baseline.
- R6: A total saturates at 0xFFFFFFFF. It never wraps and it never decreases except through clear or reset.
- R7: When `clr_i` is high at a clock edge, the totals, the baselines and `avail_o` return to their reset values. Clear takes priority over a poll in the same cycle.
- R8: In a cycle with no poll and no clear, the totals and `avail_o` keep their values, whatever the raw inputs do.
- R9: A poll that is high at a clock edge is reflected in the outputs directly after that edge. The outputs are registered, so there is one cycle of latency from the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of totals, baselines and flag |
| poll_i | input | 1 | Poll strobe; the raw words are sampled on this edge |
| raw_i | input | 64 | Two packed raw status words, word 1 in the upper half |
| total_o | output | 96 | Totals packed per DIMM; DIMM n is in bits 32n+31:32n |
| avail_o | output | 1 | High once a baseline has been taken |

## Verification
The assertions assume the following about the inputs:
- `poll_i` and `clr_i` are synchronous single-cycle qualifiers.
- The raw words only matter on a poll edge.

These assumptions are enough for the rules the checker relies on: the totals only move on a poll, they never decrease, and the flag only falls after a clear. The stimulus changes the inputs on the falling edge, which keeps it within these assumptions. It also fills every unused raw bit with random values to exercise the field positions of R2. Small random increments are mixed with large random jumps so that both the plain case (R4) and the wrap case (R5) occur often. A directed run steps every field by 32767 on each poll to drive all three totals into saturation (R6).

// File: rtl/ce_tally_pkg.sv
package ce_tally_pkg;
  parameter int unsigned CNT_W    = 15;   // raw per-DIMM counter width
  parameter int unsigned TOT_W    = 32;   // accumulated total width
  parameter int unsigned N_DIMM   = 3;    // DIMMs per channel
  parameter int unsigned WORD_W   = 32;   // raw status word width
  parameter int unsigned SLOT_W   = 16;   // spacing of fields inside a word
  localparam int unsigned PER_WORD = WORD_W / SLOT_W;
  localparam int unsigned N_WORDS  = (N_DIMM + PER_WORD - 1) / PER_WORD;
endpackage

// File: rtl/ce_unpack.sv
module ce_unpack
  import ce_tally_pkg::*;
#(
  parameter int unsigned P_DIMM  = N_DIMM,
  parameter int unsigned P_CNT_W = CNT_W,
  localparam int unsigned L_WORDS = (P_DIMM + PER_WORD - 1) / PER_WORD
) (
  input  logic [L_WORDS*WORD_W-1:0] raw_i,
  output logic [P_DIMM*P_CNT_W-1:0] fld_o
);
  logic [L_WORDS*WORD_W-1:0] used_mask;
  logic                      spare_unused;

  // Field n sits in word n/PER_WORD at slot n%PER_WORD.
  for (genvar n = 0; n < P_DIMM; n++) begin : g_fld
    localparam int unsigned BASE = (n / PER_WORD) * WORD_W + (n % PER_WORD) * SLOT_W;
    assign fld_o[n*P_CNT_W +: P_CNT_W]   = raw_i[BASE +: P_CNT_W];
    assign used_mask[BASE +: P_CNT_W]    = {P_CNT_W{1'b1}};
  end

  // Mark the remaining bits of the mask as clear.
  for (genvar b = 0; b < L_WORDS * WORD_W; b++) begin : g_gap
    localparam int unsigned SL = (b % WORD_W) / SLOT_W;
    localparam int unsigned IX = (b / WORD_W) * PER_WORD + SL;
    localparam int unsigned OF = (b % WORD_W) % SLOT_W;
    if (!(IX < P_DIMM && OF < P_CNT_W)) begin : g_z
      assign used_mask[b] = 1'b0;
    end
  end

  assign spare_unused = ^(raw_i & ~used_mask);
endmodule

// File: rtl/ce_delta.sv
module ce_delta #(
  parameter int unsigned P_CNT_W = 15
) (
  input  logic [P_CNT_W-1:0] cur_i,
  input  logic [P_CNT_W-1:0] prev_i,
  output logic [P_CNT_W-1:0] delta_o
);
  logic [P_CNT_W:0] ext;

  always_comb begin
    if (cur_i >= prev_i) begin
      ext = {1'b0, cur_i} - {1'b0, prev_i};
    end else begin
      // Counter wrapped: add one full counter range back in.
      ext = {1'b1, cur_i} - {1'b0, prev_i};
    end
    delta_o = ext[P_CNT_W-1:0];
  end
endmodule

// File: rtl/ce_satadd.sv
module ce_satadd #(
  parameter int unsigned P_TOT_W = 32,
  parameter int unsigned P_CNT_W = 15
) (
  input  logic [P_TOT_W-1:0] acc_i,
  input  logic [P_CNT_W-1:0] inc_i,
  output logic [P_TOT_W-1:0] sum_o
);
  localparam int unsigned PAD = P_TOT_W - P_CNT_W;
  logic [P_TOT_W:0] wide;

  always_comb begin
    wide = {1'b0, acc_i} + {1'b0, {PAD{1'b0}}, inc_i};
    if (wide[P_TOT_W]) begin
      sum_o = {P_TOT_W{1'b1}};
    end else begin
      sum_o = wide[P_TOT_W-1:0];
    end
  end
endmodule

// File: rtl/ce_lane.sv
module ce_lane #(
  parameter int unsigned P_TOT_W = 32,
  parameter int unsigned P_CNT_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               take_base_i,  // first poll: baseline only
  input  logic               take_acc_i,   // later poll: accumulate
  input  logic [P_CNT_W-1:0] fld_i,
  output logic [P_TOT_W-1:0] total_o
);
  logic [P_CNT_W-1:0] base_q, base_d;
  logic [P_TOT_W-1:0] tot_q,  tot_d;
  logic [P_CNT_W-1:0] step;
  logic [P_TOT_W-1:0] tot_inc;
  logic               base_en, tot_en;

  ce_delta #(.P_CNT_W(P_CNT_W)) u_delta (
    .cur_i   (fld_i),
    .prev_i  (base_q),
    .delta_o (step)
  );

  ce_satadd #(.P_TOT_W(P_TOT_W), .P_CNT_W(P_CNT_W)) u_add (
    .acc_i (tot_q),
    .inc_i (step),
    .sum_o (tot_inc)
  );

  always_comb begin
    base_en = clr_i | take_base_i | take_acc_i;
    tot_en  = clr_i | take_acc_i;
    base_d  = clr_i ? '0 : fld_i;
    tot_d   = clr_i ? '0 : tot_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
    end else if (tot_en) begin
      tot_q <= tot_d;
    end
  end

  assign total_o = tot_q;
endmodule

// File: rtl/ce_tally.sv
module ce_tally
  import ce_tally_pkg::*;
#(
  parameter int unsigned P_DIMM  = N_DIMM,
  parameter int unsigned P_CNT_W = CNT_W,
  parameter int unsigned P_TOT_W = TOT_W,
  localparam int unsigned L_WORDS = (P_DIMM + PER_WORD - 1) / PER_WORD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      poll_i,
  input  logic [L_WORDS*WORD_W-1:0] raw_i,
  output logic [P_DIMM*P_TOT_W-1:0] total_o,
  output logic                      avail_o
);
  logic [P_DIMM*P_CNT_W-1:0] fld;
  logic                      avail_q, avail_d, avail_en;
  logic                      first_poll, later_poll;

  ce_unpack #(.P_DIMM(P_DIMM), .P_CNT_W(P_CNT_W)) u_unpack (
    .raw_i (raw_i),
    .fld_o (fld)
  );

  always_comb begin
    first_poll = poll_i & ~clr_i & ~avail_q;
    later_poll = poll_i & ~clr_i &  avail_q;
    avail_en   = clr_i | first_poll;
    avail_d    = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
    end else if (avail_en) begin
      avail_q <= avail_d;
    end
  end

  for (genvar n = 0; n < P_DIMM; n++) begin : g_lane
    ce_lane #(.P_TOT_W(P_TOT_W), .P_CNT_W(P_CNT_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr_i),
      .take_base_i (first_poll),
      .take_acc_i  (later_poll),
      .fld_i       (fld[n*P_CNT_W +: P_CNT_W]),
      .total_o     (total_o[n*P_TOT_W +: P_TOT_W])
    );
  end

  assign avail_o = avail_q;
endmodule

// File: rtl/ce_tally_chk.sv
module ce_tally_chk #(
  parameter int unsigned P_DIMM  = 3,
  parameter int unsigned P_TOT_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr_i,
  input logic                      poll_i,
  input logic [P_DIMM*P_TOT_W-1:0] total_o,
  input logic                      avail_o
);
  // R3: no total may be nonzero while no baseline exists
  assert_zero_unavail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_o |-> (total_o == '0));

  // R3: the first poll only arms the flag
  assert_first_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && !clr_i && !avail_o) |=> (avail_o && total_o == '0));

  // R7: a clear empties everything on the next edge
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!avail_o && total_o == '0));

  // R7: the flag only drops after a clear
  assert_flag_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(avail_o) |-> $past(clr_i));

  // R8: idle cycles leave outputs untouched
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_i && !clr_i) |=> ($stable(total_o) && $stable(avail_o)));

  for (genvar n = 0; n < P_DIMM; n++) begin : g_mono
    // R6: totals never go down unless cleared
    assert_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (total_o[n*P_TOT_W +: P_TOT_W] >= $past(total_o[n*P_TOT_W +: P_TOT_W])));
  end
endmodule

bind ce_tally ce_tally_chk #(.P_DIMM(P_DIMM), .P_TOT_W(P_TOT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_i   (clr_i),
  .poll_i  (poll_i),
  .total_o (total_o),
  .avail_o (avail_o)
);

// File: tb/sim_ce_tally.sv
module sim_ce_tally;
  localparam int ND = 3;

  logic          clk;
  logic          rst_n;
  logic          clr_i;
  logic          poll_i;
  logic [63:0]   raw_i;
  logic [95:0]   total_o;
  logic          avail_o;

  int n_cmp;
  int n_bad;

  // bench model
  bit          m_avail;
  logic [14:0] m_base [ND];
  logic [31:0] m_tot  [ND];

  ce_tally u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .poll_i  (poll_i),
    .raw_i   (raw_i),
    .total_o (total_o),
    .avail_o (avail_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // R2 layout: f0 word0[14:0], f1 word0[30:16], f2 word1[14:0]; junk elsewhere
  function automatic logic [63:0] pack(input logic [14:0] f0, input logic [14:0] f1,
                                       input logic [14:0] f2, input logic [63:0] junk);
    logic [63:0] w;
    w = junk;
    w[14:0]  = f0;
    w[30:16] = f1;
    w[46:32] = f2;
    return w;
  endfunction

  function automatic logic [14:0] fld(input logic [63:0] w, input int n);
    case (n)
      0:       return w[14:0];
      1:       return w[30:16];
      default: return w[46:32];
    endcase
  endfunction

  // R4/R5 delta rule
  function automatic logic [31:0] dstep(input logic [14:0] cur, input logic [14:0] prev);
    if (cur >= prev) return 32'(cur) - 32'(prev);
    return 32'(cur) + 32'd32768 - 32'(prev);
  endfunction

  // R6 saturating add
  function automatic logic [31:0] sadd(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[32] ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  task automatic model_edge();
    if (clr_i) begin
      m_avail = 0;
      for (int n = 0; n < ND; n++) begin m_base[n] = '0; m_tot[n] = '0; end
    end else if (poll_i) begin
      for (int n = 0; n < ND; n++) begin
        if (m_avail) m_tot[n] = sadd(m_tot[n], dstep(fld(raw_i, n), m_base[n]));
        m_base[n] = fld(raw_i, n);
      end
      m_avail = 1;
    end
  endtask

  task automatic compare(input string req);
    n_cmp++;
    if (avail_o !== m_avail) begin
      n_bad++;
      $display("FAIL %s avail actual=%0d expected=%0d", req, avail_o, m_avail);
    end
    for (int n = 0; n < ND; n++) begin
      n_cmp++;
      if (total_o[n*32 +: 32] !== m_tot[n]) begin
        n_bad++;
        $display("FAIL %s total%0d actual=%h expected=%h", req, n, total_o[n*32 +: 32], m_tot[n]);
      end
    end
  endtask

  // one clock: drive at falling edge, sample 1ns after the rising edge (R9)
  task automatic step(input bit p, input bit c, input logic [63:0] w,
                      input string req, input bit chk);
    @(negedge clk);
    poll_i = p; clr_i = c; raw_i = w;
    @(posedge clk);
    model_edge();
    #1;
    if (chk) compare(req);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [14:0] v;
    n_cmp = 0; n_bad = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; clr_i = 1'b0; poll_i = 1'b0; raw_i = '0;
    m_avail = 0;
    for (int n = 0; n < ND; n++) begin m_base[n] = '0; m_tot[n] = '0; end
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 after release");

    // R3: baseline only
    step(1, 0, pack(15'd100, 15'd200, 15'd300, 64'hFFFF_8000_FFFF_8000), "R3 first poll", 1);
    // R8: raw moves, no poll
    step(0, 0, pack(15'd900, 15'd900, 15'd900, '0), "R8 idle", 1);
    // R4: plain increments
    step(1, 0, pack(15'd105, 15'd210, 15'd333, '0), "R4 increment", 1);
    // R9: total visible right after strobe edge
    step(1, 0, pack(15'd106, 15'd210, 15'd333, '0), "R9 latency", 1);
    // R2: only unused bits change
    step(1, 0, pack(15'd106, 15'd210, 15'd333, 64'hFFFF_8000_8000_8000 ^ 64'h5A5A_0000_0000_0000), "R2 unused bits", 1);
    // R5: wrap
    step(1, 0, pack(15'd32760, 15'd32767, 15'd333, '0), "R5 setup", 1);
    step(1, 0, pack(15'd5, 15'd0, 15'd332, '0), "R5 wrap", 1);
    // R7: clear beats poll
    step(1, 1, pack(15'd50, 15'd50, 15'd50, '0), "R7 clear with poll", 1);
    step(1, 0, pack(15'd70, 15'd80, 15'd90, '0), "R3 rebaseline", 1);
    step(1, 0, pack(15'd71, 15'd80, 15'd95, '0), "R4 after clear", 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [14:0] f [ND];
      for (int n = 0; n < ND; n++) begin
        if ($urandom_range(0, 3) == 0) f[n] = 15'($urandom);
        else f[n] = m_base[n] + 15'($urandom_range(0, 40));
      end
      step($urandom_range(0, 1) == 1, $urandom_range(0, 49) == 0,
           pack(f[0], f[1], f[2], {$urandom, $urandom}), "R4/R5/R8 random", 1);
    end

    // R6: saturation, each poll adds 32767 to every lane
    step(0, 1, '0, "R7 clear", 1);
    v = 15'd0;
    for (int i = 0; i < 131100; i++) begin
      step(1, 0, pack(v, v, v, '0), "R6 ramp", 0);
      v = v + 15'd32767;
    end
    compare("R6 saturated");
    step(1, 0, pack(v + 15'd1000, v, v, '0), "R6 hold at max", 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule